// File: doc/BRIEF.md
# Frame Buffer Read DMA

This engine streams still or alternating video frames out of system memory. Software programs the frame geometry through an AXI4-Lite slave. The geometry covers the pixels per line, the lines per frame and the byte distance between line starts. Software also loads one base address per stored frame and a control word, then sets the run bit. From then on the engine fetches every line with incrementing AXI4 read bursts. It passes the pixels through a small line FIFO and presents them on an AXI4-Stream video port. Frames follow one another with no further software action.

Each memory word carries one pixel in its low 24 bits (8 bits each of red, green and blue). The stream marks the first pixel of every frame on TUSER and the last pixel of every line on TLAST. Three frame-selection policies exist. The default steps through the stored frames in order. Park mode re-reads one chosen frame, so a still image stays on screen. Flip mode alternates between frames 0 and 1 and holds each for a programmed number of frames.

Top module: `fbr_dma`

## Requirements
- R1: After reset the status word reads halted (bit 0 = 1) with frame index 0, no AXI4 read request is raised and the stream is not valid.
- R2: Register words (byte offsets) read back what was written: 0x00 control (bit 0 run, bit 1 park, bit 2 flip), 0x08 pixels per line, 0x0C lines per frame, 0x10 stride in bytes, 0x14 park frame index, 0x18 hold count, 0x20 + 4*i base address of frame i. 0x04 is read-only status: bit 0 halted, bits 9:8 index of the frame being read.
- R3: Every read request is an INCR burst (ARBURST = 1) of 4-byte beats (ARSIZE = 2) with ARLEN at most 15, and it stays stable until accepted.
- R4: Pixels leave in row-major order. Pixel (row r, column c) of frame f equals bits 23:0 of the memory word at base[f] + r*stride + 4*c.
- R5: TUSER is 1 only on the first pixel of a frame, and TLAST is 1 only on the last pixel of each line.
- R6: With run set, frames follow back to back. After run is cleared, the frame in progress completes, status turns halted and no further read request appears.
- R7: With park and flip both clear, successive frames use indices 0, 1, ..., NFRAMES-1 and then wrap to 0.
- R8: In park mode every frame is read from the park frame index, and status bits 9:8 report it.
- R9: In flip mode (park clear) frames alternate between index 0 and index 1, with each used for the hold count of consecutive frames.
- R10: Under any TREADY pattern no pixel is lost or repeated, a valid pixel and its markers stay stable until accepted, and the line FIFO never holds more than its depth.
- R11: When park and flip are both set, park governs the frame choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sAwAddr | input | 6 | Lite write address |
| sAwValid | input | 1 | Lite write address valid |
| sAwReady | output | 1 | Lite write address ready |
| sWData | input | 32 | Lite write data |
| sWValid | input | 1 | Lite write data valid |
| sWReady | output | 1 | Lite write data ready |
| sBResp | output | 2 | Lite write response (always OKAY) |
| sBValid | output | 1 | Lite write response valid |
| sBReady | input | 1 | Lite write response ready |
| sArAddr | input | 6 | Lite read address |
| sArValid | input | 1 | Lite read address valid |
| sArReady | output | 1 | Lite read address ready |
| sRData | output | 32 | Lite read data |
| sRResp | output | 2 | Lite read response (always OKAY) |
| sRValid | output | 1 | Lite read data valid |
| sRReady | input | 1 | Lite read data ready |
| mArAddr | output | 32 | Memory read burst address |
| mArLen | output | 8 | Burst length minus one |
| mArSize | output | 3 | Beat size code |
| mArBurst | output | 2 | Burst type code |
| mArValid | output | 1 | Read request valid |
| mArReady | input | 1 | Read request ready |
| mRData | input | 32 | Read data beat |
| mRLast | input | 1 | Last beat of burst |
| mRValid | input | 1 | Read data valid |
| mRReady | output | 1 | Read data ready |
| tData | output | 24 | Stream pixel (RGB, 8 bits each) |
| tUser | output | 1 | Start-of-frame marker |
| tLast | output | 1 | End-of-line marker |
| tValid | output | 1 | Stream valid |
| tReady | input | 1 | Stream ready |

## Verification
A beat can enter the line FIFO in the same cycle that a pixel leaves it. In that same cycle the fetch side may also be deciding whether the next burst fits the space left. The bench provokes this overlap by mixing read-data gaps with continuous, one-in-three and long-stall TREADY patterns across a sweep of line widths around the 16-beat burst limit. It judges the result by checking every delivered pixel against the arithmetic address formula, with its TUSER and TLAST markers and its frame index. A lost, repeated or misordered pixel thus shows as a mismatch.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_DATA
  } engState_t;

  typedef struct packed {
    logic burstGo;
    logic frameHead;
    logic lineTail;
  } fbrStrobe_t;
endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int NFRAMES   = 3,
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 32,
  parameter int LVL_W     = 6,
  parameter int MAX_BURST = 16,
  parameter int LITE_AW   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LITE_AW-1:0] sAwAddr,
  input  logic               sAwValid,
  output logic               sAwReady,
  input  logic [31:0]        sWData,
  input  logic               sWValid,
  output logic               sWReady,
  output logic               sBValid,
  input  logic               sBReady,
  input  logic [LITE_AW-1:0] sArAddr,
  input  logic               sArValid,
  output logic               sArReady,
  output logic [31:0]        sRData,
  output logic               sRValid,
  input  logic               sRReady,
  output logic [ADDR_W-1:0]  mArAddr,
  output logic [7:0]         mArLen,
  output logic               mArValid,
  input  logic               mArReady,
  input  logic               mRValid,
  input  logic               mRLast,
  input  logic [LVL_W-1:0]   level,
  output fbrStrobe_t         strobe
);
  localparam int IDX_W     = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;
  localparam int BEAT_W    = $clog2(MAX_BURST) + 1;
  localparam int BASE_WORD = 8;

  logic [2:0]        ctrlReg;
  logic [15:0]       hSize, vSize;
  logic [ADDR_W-1:0] stride;
  logic [IDX_W-1:0]  parkIdx;
  logic [7:0]        holdFrames;
  logic [ADDR_W-1:0] frameBase [NFRAMES];

  engState_t         state;
  logic [IDX_W-1:0]  curIdx, nextIdx, startIdx;
  logic [7:0]        holdCnt, nextHold;
  logic [15:0]       row, remain;
  logic [ADDR_W-1:0] lineAddr, burstAddr;
  logic              frameHeadPend;
  logic [BEAT_W-1:0] burstBeats;
  logic              fits, arFire;
  logic [LITE_AW-3:0] wrWord, rdWord;
  logic              wrAccept, rdAccept;
  logic [31:0]       rdValue;
  logic              unusedLo;

  wire runBit  = ctrlReg[0];
  wire parkBit = ctrlReg[1];
  wire flipBit = ctrlReg[2];

  assign unusedLo = ^{sAwAddr[1:0], sArAddr[1:0]};
  assign wrWord   = sAwAddr[LITE_AW-1:2];
  assign rdWord   = sArAddr[LITE_AW-1:2];
  assign wrAccept = sAwValid && sWValid && !sBValid;
  assign rdAccept = sArValid && !sRValid;
  assign sAwReady = wrAccept;
  assign sWReady  = wrAccept;
  assign sArReady = rdAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0; hSize <= '0; vSize <= '0; stride <= '0;
      parkIdx <= '0; holdFrames <= '0; sBValid <= 1'b0;
      for (int i = 0; i < NFRAMES; i++) frameBase[i] <= '0;
    end else if (wrAccept) begin
      sBValid <= 1'b1;
      case (int'(wrWord))
        0: ctrlReg    <= sWData[2:0];
        2: hSize      <= sWData[15:0];
        3: vSize      <= sWData[15:0];
        4: stride     <= sWData[ADDR_W-1:0];
        5: parkIdx    <= sWData[IDX_W-1:0];
        6: holdFrames <= sWData[7:0];
        default: ;
      endcase
      for (int i = 0; i < NFRAMES; i++)
        if (int'(wrWord) == BASE_WORD + i) frameBase[i] <= sWData[ADDR_W-1:0];
    end else if (sBReady) begin
      sBValid <= 1'b0;
    end
  end

  always_comb begin
    rdValue = '0;
    case (int'(rdWord))
      0: rdValue = 32'(ctrlReg);
      1: begin
        rdValue[0]          = (state == ENG_IDLE);
        rdValue[8 +: IDX_W] = curIdx;
      end
      2: rdValue = 32'(hSize);
      3: rdValue = 32'(vSize);
      4: rdValue = 32'(stride);
      5: rdValue = 32'(parkIdx);
      6: rdValue = 32'(holdFrames);
      default: ;
    endcase
    for (int i = 0; i < NFRAMES; i++)
      if (int'(rdWord) == BASE_WORD + i) rdValue = 32'(frameBase[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sRValid <= 1'b0;
      sRData  <= '0;
    end else if (rdAccept) begin
      sRValid <= 1'b1;
      sRData  <= rdValue;
    end else if (sRReady) begin
      sRValid <= 1'b0;
    end
  end

  // frame selection: park wins over flip, flip over ring order
  always_comb begin
    nextIdx  = curIdx;
    nextHold = '0;
    if (parkBit) begin
      nextIdx = parkIdx;
    end else if (flipBit) begin
      if (holdCnt + 8'd1 >= holdFrames) nextIdx = (curIdx == '0) ? IDX_W'(1) : '0;
      else nextHold = holdCnt + 8'd1;
    end else begin
      nextIdx = (int'(curIdx) == NFRAMES - 1) ? '0 : curIdx + 1'b1;
    end
  end
  assign startIdx = parkBit ? parkIdx : '0;

  assign burstBeats = (remain > 16'(MAX_BURST)) ? BEAT_W'(MAX_BURST) : BEAT_W'(remain);
  assign fits       = (int'(level) + int'(burstBeats)) <= DEPTH;
  assign mArValid   = (state == ENG_ADDR) && fits;
  assign mArAddr    = burstAddr;
  assign mArLen     = 8'(burstBeats - 1'b1);
  assign arFire     = mArValid && mArReady;

  assign strobe.burstGo   = arFire;
  assign strobe.frameHead = frameHeadPend;
  assign strobe.lineTail  = (remain == 16'(burstBeats));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ENG_IDLE; curIdx <= '0; holdCnt <= '0; row <= '0; remain <= '0;
      lineAddr <= '0; burstAddr <= '0; frameHeadPend <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (runBit) begin
          curIdx <= startIdx; holdCnt <= '0;
          lineAddr <= frameBase[startIdx]; burstAddr <= frameBase[startIdx];
          row <= '0; remain <= hSize; frameHeadPend <= 1'b1; state <= ENG_ADDR;
        end
        ENG_ADDR: if (arFire) begin
          frameHeadPend <= 1'b0;
          state <= ENG_DATA;
        end
        default: if (mRValid && mRLast) begin
          if (remain != 16'(burstBeats)) begin
            remain    <= remain - 16'(burstBeats);
            burstAddr <= burstAddr + ADDR_W'({burstBeats, 2'b00});
            state     <= ENG_ADDR;
          end else if (row != vSize - 16'd1) begin
            row       <= row + 16'd1;
            lineAddr  <= lineAddr + stride;
            burstAddr <= lineAddr + stride;
            remain    <= hSize;
            state     <= ENG_ADDR;
          end else if (runBit) begin
            curIdx <= nextIdx; holdCnt <= nextHold;
            lineAddr <= frameBase[nextIdx]; burstAddr <= frameBase[nextIdx];
            row <= '0; remain <= hSize; frameHeadPend <= 1'b1; state <= ENG_ADDR;
          end else begin
            state <= ENG_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int PIX_W  = 24,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbrStrobe_t        strobe,
  input  logic [DATA_W-1:0] mRData,
  input  logic              mRValid,
  input  logic              mRLast,
  output logic              mRReady,
  output logic [PIX_W-1:0]  tData,
  output logic              tUser,
  output logic              tLast,
  output logic              tValid,
  input  logic              tReady,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = PIX_W + 2;

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             headPend, tailBurst;
  logic             push, pop;
  logic             unusedHigh;

  assign unusedHigh = ^mRData[DATA_W-1:PIX_W];
  assign mRReady = 1'b1;   // room is reserved before each burst is requested
  assign push    = mRValid;
  assign tValid  = (level != '0);
  assign pop     = tValid && tReady;
  assign {tUser, tLast, tData} = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= {headPend, tailBurst && mRLast, mRData[PIX_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; level <= '0;
      headPend <= 1'b0; tailBurst <= 1'b0;
    end else begin
      if (strobe.burstGo) begin
        headPend  <= strobe.frameHead;
        tailBurst <= strobe.lineTail;
      end else if (push) begin
        headPend <= 1'b0;
      end
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end
endmodule

// File: rtl/fbr_dma.sv
module fbr_dma
  import fbr_pkg::*;
#(
  parameter int NFRAMES   = 3,
  parameter int DEPTH     = 32,
  parameter int MAX_BURST = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  sAwAddr,
  input  logic        sAwValid,
  output logic        sAwReady,
  input  logic [31:0] sWData,
  input  logic        sWValid,
  output logic        sWReady,
  output logic [1:0]  sBResp,
  output logic        sBValid,
  input  logic        sBReady,
  input  logic [5:0]  sArAddr,
  input  logic        sArValid,
  output logic        sArReady,
  output logic [31:0] sRData,
  output logic [1:0]  sRResp,
  output logic        sRValid,
  input  logic        sRReady,
  output logic [31:0] mArAddr,
  output logic [7:0]  mArLen,
  output logic [2:0]  mArSize,
  output logic [1:0]  mArBurst,
  output logic        mArValid,
  input  logic        mArReady,
  input  logic [31:0] mRData,
  input  logic        mRLast,
  input  logic        mRValid,
  output logic        mRReady,
  output logic [23:0] tData,
  output logic        tUser,
  output logic        tLast,
  output logic        tValid,
  input  logic        tReady
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  fbrStrobe_t       strobe;
  logic [LVL_W-1:0] fifoLevel;

  assign sBResp   = 2'b00;
  assign sRResp   = 2'b00;
  assign mArSize  = 3'd2;
  assign mArBurst = 2'd1;

  fbr_ctrl #(
    .NFRAMES(NFRAMES), .ADDR_W(32), .DEPTH(DEPTH), .LVL_W(LVL_W),
    .MAX_BURST(MAX_BURST), .LITE_AW(6)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .sAwAddr(sAwAddr), .sAwValid(sAwValid), .sAwReady(sAwReady),
    .sWData(sWData), .sWValid(sWValid), .sWReady(sWReady),
    .sBValid(sBValid), .sBReady(sBReady),
    .sArAddr(sArAddr), .sArValid(sArValid), .sArReady(sArReady),
    .sRData(sRData), .sRValid(sRValid), .sRReady(sRReady),
    .mArAddr(mArAddr), .mArLen(mArLen), .mArValid(mArValid), .mArReady(mArReady),
    .mRValid(mRValid), .mRLast(mRLast), .level(fifoLevel), .strobe(strobe)
  );

  fbr_datapath #(
    .DEPTH(DEPTH), .PIX_W(24), .DATA_W(32), .LVL_W(LVL_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mRData(mRData), .mRValid(mRValid), .mRLast(mRLast), .mRReady(mRReady),
    .tData(tData), .tUser(tUser), .tLast(tLast), .tValid(tValid), .tReady(tReady),
    .level(fifoLevel)
  );
endmodule

// File: rtl/fbr_dma_chk.sv
module fbr_dma_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             mArValid,
  input logic             mArReady,
  input logic [31:0]      mArAddr,
  input logic [7:0]       mArLen,
  input logic [2:0]       mArSize,
  input logic [1:0]       mArBurst,
  input logic             tValid,
  input logic             tReady,
  input logic [23:0]      tData,
  input logic             tUser,
  input logic             tLast,
  input logic [LVL_W-1:0] fifoLevel
);
  // R3
  burst_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    mArValid |-> (mArLen <= 8'd15) && (mArSize == 3'd2) && (mArBurst == 2'd1));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mArValid && !mArReady |=> mArValid && $stable(mArAddr) && $stable(mArLen));

  // R10
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    tValid && !tReady |=> tValid && $stable(tData) && $stable(tUser) && $stable(tLast));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoLevel) <= DEPTH);
endmodule

bind fbr_dma fbr_dma_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .mArValid(mArValid), .mArReady(mArReady),
  .mArAddr(mArAddr), .mArLen(mArLen), .mArSize(mArSize), .mArBurst(mArBurst),
  .tValid(tValid), .tReady(tReady), .tData(tData), .tUser(tUser), .tLast(tLast),
  .fifoLevel(fifoLevel)
);

// File: tb/fbr_dma_tb.sv
module fbr_dma_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  sAwAddr = '0, sArAddr = '0;
  logic        sAwValid = 0, sWValid = 0, sArValid = 0;
  logic [31:0] sWData = '0;
  logic        sAwReady, sWReady, sBValid, sArReady, sRValid;
  logic [1:0]  sBResp, sRResp;
  logic [31:0] sRData;
  logic [31:0] mArAddr, mRData;
  logic [7:0]  mArLen;
  logic [2:0]  mArSize;
  logic [1:0]  mArBurst;
  logic        mArValid, mArReady, mRLast, mRValid, mRReady;
  logic [23:0] tData;
  logic        tUser, tLast, tValid, tReady;

  fbr_dma dut_i (
    .clk(clk), .rstN(rstN),
    .sAwAddr(sAwAddr), .sAwValid(sAwValid), .sAwReady(sAwReady),
    .sWData(sWData), .sWValid(sWValid), .sWReady(sWReady),
    .sBResp(sBResp), .sBValid(sBValid), .sBReady(1'b1),
    .sArAddr(sArAddr), .sArValid(sArValid), .sArReady(sArReady),
    .sRData(sRData), .sRResp(sRResp), .sRValid(sRValid), .sRReady(1'b1),
    .mArAddr(mArAddr), .mArLen(mArLen), .mArSize(mArSize), .mArBurst(mArBurst),
    .mArValid(mArValid), .mArReady(mArReady),
    .mRData(mRData), .mRLast(mRLast), .mRValid(mRValid), .mRReady(mRReady),
    .tData(tData), .tUser(tUser), .tLast(tLast), .tValid(tValid), .tReady(tReady)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] bases [3] = '{32'h1000, 32'h4000, 32'h8000};

  // scenario configuration
  int cfgH = 1, cfgV = 1, cfgStride = 4, cfgMode = 0, cfgPark = 0, cfgHold = 1;
  int rdyMode = 0, gapOn = 0;
  string dataTag = "R4";

  // monitor state
  int framesSeen = 0, framesDone = 0, mRow = 0, mCol = 0, curExp = 0;
  int beatsLeft = 0, arCount = 0;
  logic [31:0] curAddr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {8'h5A, a[23:0] ^ 24'hC3A55A};
  endfunction

  // mode: 0 ring, 1 park, 2 flip, 3 park+flip
  function automatic int expIdx(input int n);
    if (cfgMode == 1 || cfgMode == 3) return cfgPark;
    if (cfgMode == 2) return (n / cfgHold) % 2;
    return n % 3;
  endfunction

  // behavioural memory slave
  always @(negedge clk) begin
    if (!rstN) begin
      mArReady = 0; mRValid = 0; mRLast = 0; mRData = '0; beatsLeft = 0;
    end else begin
      if (beatsLeft > 0 && !(gapOn != 0 && cyc % 5 == 2)) begin
        mRValid = 1; mRData = memWord(curAddr); mRLast = (beatsLeft == 1);
        curAddr += 4; beatsLeft--;
      end else begin
        mRValid = 0; mRLast = 0;
      end
      mArReady = (beatsLeft == 0) && !mRValid;
      if (mArReady && mArValid) begin
        // R3 burst shape
        check(mArLen <= 15 && mArSize == 2 && mArBurst == 1, "R3", "burst shape",
              {mArLen, 5'd0, mArSize, 14'd0, mArBurst}, 32'h0F000000 | 32'h20001);
        beatsLeft = int'(mArLen) + 1; curAddr = mArAddr; arCount++;
      end
    end
  end

  // stream sink and pixel monitor
  always @(negedge clk) begin
    if (!rstN) tReady = 0;
    else begin
      case (rdyMode)
        1: tReady = (cyc % 3) != 0;
        2: tReady = (cyc % 24) >= 20;
        default: tReady = 1;
      endcase
      if (tValid && tReady) begin
        logic [31:0] a;
        if (mRow == 0 && mCol == 0) begin
          curExp = expIdx(framesSeen);
          framesSeen++;
        end
        a = bases[curExp] + 32'(mRow * cfgStride) + 32'(mCol * 4);
        check(tData == memWord(a)[23:0], dataTag, "pixel", 32'(tData), 32'(memWord(a)[23:0]));
        // R5 markers
        check(tUser == (mRow == 0 && mCol == 0) && tLast == (mCol == cfgH - 1), "R5", "markers",
              {30'd0, tUser, tLast}, {30'd0, 1'(mRow == 0 && mCol == 0), 1'(mCol == cfgH - 1)});
        mCol++;
        if (mCol == cfgH) begin
          mCol = 0; mRow++;
          if (mRow == cfgV) begin mRow = 0; framesDone++; end
        end
      end
    end
  end

  task automatic liteWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); sAwAddr = a; sWData = d; sAwValid = 1; sWValid = 1; #1;
    while (!sAwReady) begin @(negedge clk); #1; end
    @(negedge clk); sAwValid = 0; sWValid = 0;
    @(negedge clk);
  endtask

  task automatic liteRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); sArAddr = a; sArValid = 1; #1;
    while (!sArReady) begin @(negedge clk); #1; end
    @(negedge clk); sArValid = 0; d = sRData;
    @(negedge clk);
  endtask

  task automatic runCase(input int h, input int v, input int strideB, input int mode,
                         input int park, input int hold, input int rdy, input int gap,
                         input int minFrames, input string tag);
    logic [31:0] d;
    int arSnap;
    logic [31:0] ctrlBits;
    cfgH = h; cfgV = v; cfgStride = strideB; cfgMode = mode; cfgPark = park;
    cfgHold = (hold < 1) ? 1 : hold; rdyMode = rdy; gapOn = gap; dataTag = tag;
    framesSeen = 0; framesDone = 0; mRow = 0; mCol = 0;
    ctrlBits = (mode == 1) ? 32'h2 : (mode == 2) ? 32'h4 : (mode == 3) ? 32'h6 : 32'h0;
    liteWrite(6'h08, 32'(h)); liteWrite(6'h0C, 32'(v)); liteWrite(6'h10, 32'(strideB));
    liteWrite(6'h14, 32'(park)); liteWrite(6'h18, 32'(hold));
    liteWrite(6'h00, ctrlBits | 32'h1);
    while (framesSeen < minFrames) @(negedge clk);
    if (mode == 1) begin
      liteRead(6'h04, d);
      // R8 status shows parked index while running
      check(d[0] == 0 && d[9:8] == 2'(park), "R8", "status running/index", d, 32'(park) << 8);
    end
    liteWrite(6'h00, 32'h0);
    do liteRead(6'h04, d); while (!d[0]);
    arSnap = arCount;
    rdyMode = 0;
    repeat (120) @(negedge clk);
    // R6 stop behaviour
    check(arCount == arSnap, "R6", "no fetch after halt", 32'(arCount), 32'(arSnap));
    check(framesDone == framesSeen && mRow == 0 && mCol == 0, "R6", "whole frames",
          32'(framesDone), 32'(framesSeen));
    check(framesSeen >= minFrames, "R6", "frames delivered", 32'(framesSeen), 32'(minFrames));
  endtask

  initial begin
    int hs [8] = '{1, 2, 15, 16, 17, 31, 33, 40};
    logic [31:0] d;
    int k = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(tValid == 0 && mArValid == 0, "R1", "quiet after reset", {tValid, mArValid}, 0);
    liteRead(6'h04, d);
    check(d[0] == 1 && d[9:8] == 0, "R1", "status halted", d, 1);

    for (int i = 0; i < 3; i++) liteWrite(6'(32 + 4 * i), bases[i]);
    // R2 register readback
    liteWrite(6'h08, 32'h1234); liteRead(6'h08, d); check(d == 32'h1234, "R2", "hsize", d, 32'h1234);
    liteWrite(6'h0C, 32'h7);    liteRead(6'h0C, d); check(d == 32'h7, "R2", "vsize", d, 32'h7);
    liteWrite(6'h10, 32'hABCD0); liteRead(6'h10, d); check(d == 32'hABCD0, "R2", "stride", d, 32'hABCD0);
    liteWrite(6'h14, 32'h2);    liteRead(6'h14, d); check(d == 32'h2, "R2", "park", d, 32'h2);
    liteWrite(6'h18, 32'h5);    liteRead(6'h18, d); check(d == 32'h5, "R2", "hold", d, 32'h5);
    liteWrite(6'h00, 32'h6);    liteRead(6'h00, d); check(d == 32'h6, "R2", "control", d, 32'h6);
    liteRead(6'h28, d); check(d == bases[2], "R2", "frame base 2", d, bases[2]);
    liteRead(6'h04, d); check(d[0] == 1, "R2", "status still halted", d, 1);
    liteWrite(6'h00, 32'h0);

    // R4 R7 sweep of geometry, ready patterns and read gaps
    foreach (hs[i]) begin
      for (int v = 1; v <= 3; v++) begin
        runCase(hs[i], v, hs[i] * 4 + (v % 2) * 64, 0, 0, 1, k % 3, k % 2, 1, "R4");
        k++;
      end
    end
    runCase(4, 2, 32, 0, 0, 1, 1, 0, 4, "R7");
    runCase(6, 2, 64, 1, 2, 1, 0, 1, 3, "R8");
    runCase(3, 2, 16, 2, 0, 2, 2, 0, 5, "R9");
    runCase(5, 2, 20, 3, 1, 2, 1, 1, 3, "R11");
    runCase(40, 3, 192, 0, 0, 1, 2, 1, 2, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired (R6) actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule